// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block is a fully associative translation buffer that turns a 64-bit virtual address into a 41-bit physical address. It holds a parameterised number of entries (64 by default). Each entry carries a virtual page tag, a 13-bit context, a physical page number, a 2-bit page size and six attribute bits: valid, global, privileged, writable, no-fault-only and side-effect. A used bit per entry is kept alongside. Each entry compares the address under its own size mask, so pages of 8 KB, 64 KB, 512 KB and 4 MB can sit in the same array.

A lookup is offered with `lk_valid` and is answered combinationally in the same cycle. The block always accepts a lookup, so there is no ready signal and no back-pressure. The result is a hit with physical address and permissions, a data or instruction miss, a data fault, a protection fault or an instruction fault. Misses and faults update a tag-capture register. Faults also update a fault status register and a fault address register. A fill port writes one whole entry in a single cycle. Replacement and refill are left to the surrounding logic, which can read the used bits.

Top module: `vtlb_xlate`

## Requirements
- R1: An entry hits when it is valid, its tag matches the virtual address above the page offset of its size (size code 0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB), and either its global bit is set or its context equals the lookup context.
- R2: On a hit, `lk_pa` takes the entry's page bits above the page offset and the virtual address bits inside the page offset, limited to bits 40:13, with bits 12:0 zero. `lk_pa` is zero whenever the result is not a hit.
- R3: For a data lookup, `lk_space` selects the context: 0 is the primary context, 1 is the secondary context, and 2 or 3 is the nucleus context, which is 0. An instruction lookup uses the primary context when `trap_level_nz` is 0 and the nucleus context otherwise.
- R4: When several entries hit, the entry with the lowest index supplies the result.
- R5: A fill replaces the whole entry at `fill_idx` and clears its used bit. The new contents are seen by a lookup in the next cycle, and a lookup in the same cycle still sees the old contents. If a fill and a used-bit set target the same entry in the same cycle, the fill wins.
- R6: On a data hit, the following cause bits are raised and any of them gives result code 3 (data fault):
  - a user access to a privileged entry raises cause bit 0;
  - a no-fault load to a side-effect entry raises cause bit 1;
  - a data access without the no-fault flag to a no-fault-only entry raises cause bit 2.
- R7: A data store that hits an entry whose writable bit is clear gives result code 4 (protection fault), but only when no R6 cause is present.
- R8: On any fault (result codes 3, 4, 6), `fault_status` is rewritten as follows, and `fault_addr` takes the full virtual address:
  - bit 0: valid, set to 1;
  - bit 1: overflow, set to the previous value of bit 0;
  - bits 3:2: context class (0 primary, 1 secondary, 2 nucleus);
  - bit 4: write flag (0 for instruction lookups);
  - bit 5: no-fault flag (0 for instruction lookups);
  - bit 6: `priv_mode`;
  - bits 9:7: cause bits 2..0.
- R9: On a miss (codes 2, 5) or a fault, `tag_access` takes the virtual address bits 63:13 with the lookup context in bits 12:0. A miss leaves `fault_status` and `fault_addr` unchanged.
- R10: A lookup whose result is a hit sets the used bit of the selected entry.
- R11: A data hit grants read, and also write when the writable bit is set. An instruction hit grants execute only. A user instruction lookup that hits a privileged entry gives result code 6 (instruction fault) with cause bit 0.
- R12: `lk_res` encodes 0 = idle, 1 = hit, 2 = data miss, 3 = data fault, 4 = protection fault, 5 = instruction miss, 6 = instruction fault. After reset all entries are invalid, and all used bits, `tag_access`, `fault_status` and `fault_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Write one entry this cycle |
| fill_idx | input | 6 | Entry index to write |
| fill_vpn | input | 51 | Virtual page tag (address bits 63:13) |
| fill_ctx | input | 13 | Entry context |
| fill_ppn | input | 28 | Physical page (address bits 40:13) |
| fill_size | input | 2 | Page size code |
| fill_valid | input | 1 | Entry valid |
| fill_global | input | 1 | Match any context |
| fill_priv | input | 1 | Privileged-only page |
| fill_writable | input | 1 | Stores permitted |
| fill_nfo | input | 1 | Page only for no-fault loads |
| fill_side | input | 1 | Page has side effects |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_va | input | 64 | Lookup virtual address |
| lk_instr | input | 1 | Instruction lookup (else data) |
| lk_space | input | 2 | Data context select |
| lk_user | input | 1 | Access from user mode |
| lk_write | input | 1 | Data store |
| lk_nofault | input | 1 | No-fault data load |
| trap_level_nz | input | 1 | Trap level is above zero |
| priv_mode | input | 1 | Processor privilege mode, recorded on fault |
| primary_ctx | input | 13 | Primary context |
| secondary_ctx | input | 13 | Secondary context |
| lk_res | output | 3 | Result code |
| lk_pa | output | 41 | Physical address on hit |
| lk_rd | output | 1 | Read granted |
| lk_wr | output | 1 | Write granted |
| lk_ex | output | 1 | Execute granted |
| tag_access | output | 64 | Captured page and context of last miss or fault |
| fault_status | output | 10 | Fault status |
| fault_addr | output | 64 | Fault virtual address |
| entry_used | output | 64 | Used bit per entry |

## Verification
The hardest case to reach from the ports is a lookup that matches two entries at once: one pair under the same context and one pair mixing a global entry with a context-matched one. In both, the low-index entry must be chosen and only its used bit set. The stimulus builds such pairs on purpose, invalidates the winner with a fill, and then looks up again to see the other entry take over. A second hard case is a fill and a hit on the same index in the same cycle. The bench drives both together and checks that the lookup result comes from the old entry while the used bit ends up cleared. Large pages are reached by probing addresses near both edges of 64 KB, 512 KB and 4 MB pages, including one address just past the edge, which must miss.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int VA_W  = 64;
  localparam int PA_W  = 41;
  localparam int PG_SH = 13;
  localparam int CTX_W = 13;
  localparam int VPN_W = VA_W - PG_SH;
  localparam int PPN_W = PA_W - PG_SH;
  localparam int FSR_W = 10;

  typedef struct packed {
    logic prv;
    logic wok;
    logic nfo;
    logic sfx;
  } flags_t;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [CTX_W-1:0] ctx;
    logic [PPN_W-1:0] ppn;
    logic [1:0]       size;
    logic             vld;
    logic             glb;
    flags_t           fl;
  } tte_t;

  typedef enum logic [2:0] {
    RES_NONE   = 3'd0,
    RES_HIT    = 3'd1,
    RES_DMISS  = 3'd2,
    RES_DFAULT = 3'd3,
    RES_DPROT  = 3'd4,
    RES_IMISS  = 3'd5,
    RES_IFAULT = 3'd6
  } res_e;

  // page-number compare mask: each size step drops three more low bits
  function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    return m << (32'(sz) * 3);
  endfunction
endpackage

// File: rtl/vtlb_cam.sv
module vtlb_cam
  import vtlb_pkg::*;
#(
  parameter int NUM_ENT = 64,
  localparam int IW = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  tte_t               wr_ent,
  input  logic               mark_en,
  input  logic [IW-1:0]      mark_idx,
  input  logic [VPN_W-1:0]   q_vpn,
  input  logic [CTX_W-1:0]   q_ctx,
  output logic               hit,
  output logic [IW-1:0]      hit_idx,
  output logic [PPN_W-1:0]   hit_ppn,
  output logic [1:0]         hit_size,
  output flags_t             hit_flags,
  output logic [NUM_ENT-1:0] used_vec
);
  logic [NUM_ENT-1:0] match;
  logic [PPN_W-1:0]   ppn_a  [NUM_ENT];
  logic [1:0]         size_a [NUM_ENT];
  flags_t             flg_a  [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    tte_t             ent_q;
    logic             used_q;
    logic [VPN_W-1:0] msk;

    assign msk      = size_mask(ent_q.size);
    assign match[i] = ent_q.vld && ((ent_q.vpn & msk) == (q_vpn & msk)) &&
                      (ent_q.glb || (ent_q.ctx == q_ctx));
    assign ppn_a[i]  = ent_q.ppn;
    assign size_a[i] = ent_q.size;
    assign flg_a[i]  = ent_q.fl;
    assign used_vec[i] = used_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q  <= '0;
        used_q <= 1'b0;
      end else if (wr_en && (wr_idx == IW'(i))) begin
        ent_q  <= wr_ent;
        used_q <= 1'b0;
      end else if (mark_en && (mark_idx == IW'(i))) begin
        used_q <= 1'b1;
      end
    end
  end

  // lowest index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign hit_ppn   = ppn_a[hit_idx];
  assign hit_size  = size_a[hit_idx];
  assign hit_flags = flg_a[hit_idx];

  AST_FILL_CLEARS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !used_vec[$past(wr_idx)]); // R5
  AST_HIT_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !wr_en) |=> used_vec[$past(mark_idx)]); // R10
endmodule

// File: rtl/vtlb_check.sv
module vtlb_check
  import vtlb_pkg::*;
(
  input  logic       lk_valid,
  input  logic       hit,
  input  logic       is_instr,
  input  logic       user,
  input  logic       write,
  input  logic       nofault,
  input  flags_t     fl,
  output res_e       res,
  output logic       rd,
  output logic       wr,
  output logic       ex,
  output logic [2:0] cause
);
  always_comb begin
    res   = RES_NONE;
    cause = '0;
    rd    = 1'b0;
    wr    = 1'b0;
    ex    = 1'b0;
    if (lk_valid) begin
      if (!hit) begin
        res = is_instr ? RES_IMISS : RES_DMISS;
      end else if (is_instr) begin
        if (fl.prv && user) begin
          cause[0] = 1'b1;
          res      = RES_IFAULT;
        end else begin
          res = RES_HIT;
          ex  = 1'b1;
        end
      end else begin
        cause[0] = fl.prv && user;
        if (nofault) cause[1] = fl.sfx;
        else         cause[2] = fl.nfo;
        if (|cause)                 res = RES_DFAULT;
        else if (write && !fl.wok)  res = RES_DPROT;
        else begin
          res = RES_HIT;
          rd  = 1'b1;
          wr  = fl.wok;
        end
      end
    end
  end
endmodule

// File: rtl/vtlb_status.sv
module vtlb_status
  import vtlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  res_e             res,
  input  logic [2:0]       cause,
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  input  logic [1:0]       cls,
  input  logic             wflag,
  input  logic             nflag,
  input  logic             priv_mode,
  output logic [VA_W-1:0]  tag_acc,
  output logic [FSR_W-1:0] fsr,
  output logic [VA_W-1:0]  far
);
  logic is_fault, is_miss;
  assign is_fault = (res == RES_DFAULT) || (res == RES_DPROT) || (res == RES_IFAULT);
  assign is_miss  = (res == RES_DMISS)  || (res == RES_IMISS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_acc <= '0;
      fsr     <= '0;
      far     <= '0;
    end else begin
      if (is_fault || is_miss) tag_acc <= {va[VA_W-1:PG_SH], ctx};
      if (is_fault) begin
        fsr <= {cause, priv_mode, nflag, wflag, cls, fsr[0], 1'b1};
        far <= va;
      end
    end
  end

  AST_MISS_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    is_miss |=> ($stable(fsr) && $stable(far))); // R9
  AST_FAULT_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    is_fault |=> fsr[0]); // R8
  AST_OVERFLOW_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fault && fsr[0]) |=> fsr[1]); // R8
endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
  import vtlb_pkg::*;
#(
  parameter int NUM_ENT = 64,
  localparam int IW = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [IW-1:0]      fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [CTX_W-1:0]   fill_ctx,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [1:0]         fill_size,
  input  logic               fill_valid,
  input  logic               fill_global,
  input  logic               fill_priv,
  input  logic               fill_writable,
  input  logic               fill_nfo,
  input  logic               fill_side,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_va,
  input  logic               lk_instr,
  input  logic [1:0]         lk_space,
  input  logic               lk_user,
  input  logic               lk_write,
  input  logic               lk_nofault,
  input  logic               trap_level_nz,
  input  logic               priv_mode,
  input  logic [CTX_W-1:0]   primary_ctx,
  input  logic [CTX_W-1:0]   secondary_ctx,
  output logic [2:0]         lk_res,
  output logic [PA_W-1:0]    lk_pa,
  output logic               lk_rd,
  output logic               lk_wr,
  output logic               lk_ex,
  output logic [VA_W-1:0]    tag_access,
  output logic [FSR_W-1:0]   fault_status,
  output logic [VA_W-1:0]    fault_addr,
  output logic [NUM_ENT-1:0] entry_used
);
  logic [CTX_W-1:0] cur_ctx;
  logic [1:0]       cls;
  tte_t             wr_ent;
  logic             hit;
  logic [IW-1:0]    hit_idx;
  logic [PPN_W-1:0] hit_ppn;
  logic [1:0]       hit_size;
  flags_t           hit_flags;
  res_e             res;
  logic [2:0]       cause;
  logic [VPN_W-1:0] full_msk;
  logic [PPN_W-1:0] pmsk, pa_hi;

  // context and class selection
  always_comb begin
    if (lk_instr) begin
      cur_ctx = trap_level_nz ? '0 : primary_ctx;
      cls     = trap_level_nz ? 2'd2 : 2'd0;
    end else begin
      unique case (lk_space)
        2'd0:    begin cur_ctx = primary_ctx;   cls = 2'd0; end
        2'd1:    begin cur_ctx = secondary_ctx; cls = 2'd1; end
        default: begin cur_ctx = '0;            cls = 2'd2; end
      endcase
    end
  end

  assign wr_ent = '{vpn: fill_vpn, ctx: fill_ctx, ppn: fill_ppn, size: fill_size,
                    vld: fill_valid, glb: fill_global,
                    fl: '{prv: fill_priv, wok: fill_writable, nfo: fill_nfo, sfx: fill_side}};

  vtlb_cam #(.NUM_ENT(NUM_ENT)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_en), .wr_idx(fill_idx), .wr_ent(wr_ent),
    .mark_en(res == RES_HIT), .mark_idx(hit_idx),
    .q_vpn(lk_va[VA_W-1:PG_SH]), .q_ctx(cur_ctx),
    .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn), .hit_size(hit_size),
    .hit_flags(hit_flags), .used_vec(entry_used)
  );

  vtlb_check u_chk (
    .lk_valid(lk_valid), .hit(hit), .is_instr(lk_instr), .user(lk_user),
    .write(lk_write), .nofault(lk_nofault), .fl(hit_flags),
    .res(res), .rd(lk_rd), .wr(lk_wr), .ex(lk_ex), .cause(cause)
  );

  vtlb_status u_stat (
    .clk(clk), .rst_n(rst_n), .res(res), .cause(cause), .va(lk_va),
    .ctx(cur_ctx), .cls(cls), .wflag(!lk_instr && lk_write),
    .nflag(!lk_instr && lk_nofault), .priv_mode(priv_mode),
    .tag_acc(tag_access), .fsr(fault_status), .far(fault_addr)
  );

  // physical page: entry bits above the offset, address bits inside it
  assign full_msk = size_mask(hit_size);
  assign pmsk     = full_msk[PPN_W-1:0];
  assign pa_hi    = (hit_ppn & pmsk) | (lk_va[PA_W-1:PG_SH] & ~pmsk);
  assign lk_pa    = (res == RES_HIT) ? {pa_hi, {PG_SH{1'b0}}} : '0;
  assign lk_res   = res;

  AST_HIT_ONE_PERM_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_res == 3'd1) |-> (lk_rd ^ lk_ex)); // R11
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (lk_res == 3'd0 && !lk_rd && !lk_wr && !lk_ex && lk_pa == '0)); // R12
endmodule

// File: tb/vtlb_xlate_bench.sv
module vtlb_xlate_bench;
  localparam int N = 64;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        fill_en, fill_valid, fill_global, fill_priv, fill_writable, fill_nfo, fill_side;
  logic [5:0]  fill_idx;
  logic [50:0] fill_vpn;
  logic [12:0] fill_ctx, primary_ctx, secondary_ctx;
  logic [27:0] fill_ppn;
  logic [1:0]  fill_size, lk_space;
  logic        lk_valid, lk_instr, lk_user, lk_write, lk_nofault, trap_level_nz, priv_mode;
  logic [63:0] lk_va;
  logic [2:0]  lk_res;
  logic [40:0] lk_pa;
  logic        lk_rd, lk_wr, lk_ex;
  logic [63:0] tag_access, fault_addr;
  logic [9:0]  fault_status;
  logic [N-1:0] entry_used;

  vtlb_xlate u_vtlb_xlate (.*);

  // reference model state
  logic [63:0] m_va [N];
  logic [12:0] m_cx [N];
  logic [40:0] m_pa [N];
  int          m_sz [N];
  bit m_v [N], m_g [N], m_p [N], m_w [N], m_n [N], m_s [N];
  logic [N-1:0] m_used;
  logic [9:0]  m_fsr;
  logic [63:0] m_far, m_tag;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input string req);
    logic [12:0] ctx; logic [1:0] cls; int idx; int eres;
    logic [63:0] mask, epa; bit er, ew, ex; logic [2:0] cause;
    #3;
    if (lk_instr) begin ctx = trap_level_nz ? 13'd0 : primary_ctx; cls = trap_level_nz ? 2'd2 : 2'd0; end
    else if (lk_space == 0) begin ctx = primary_ctx; cls = 0; end
    else if (lk_space == 1) begin ctx = secondary_ctx; cls = 1; end
    else begin ctx = 0; cls = 2; end
    idx = -1;
    for (int i = 0; i < N; i++) begin
      mask = ~((64'd8192 << (3 * m_sz[i])) - 64'd1);
      if (idx < 0 && m_v[i] && ((m_va[i] & mask) == (lk_va & mask)) && (m_g[i] || m_cx[i] == ctx))
        idx = i;
    end
    eres = 0; epa = 0; er = 0; ew = 0; ex = 0; cause = 0;
    if (lk_valid) begin
      if (idx < 0) eres = lk_instr ? 5 : 2;
      else begin
        mask = ~((64'd8192 << (3 * m_sz[idx])) - 64'd1);
        if (lk_instr) begin
          if (m_p[idx] && lk_user) begin cause = 3'b001; eres = 6; end
          else begin eres = 1; ex = 1; end
        end else begin
          cause[0] = m_p[idx] && lk_user;
          if (lk_nofault) cause[1] = m_s[idx]; else cause[2] = m_n[idx];
          if (cause != 0) eres = 3;
          else if (lk_write && !m_w[idx]) eres = 4;
          else begin eres = 1; er = 1; ew = m_w[idx]; end
        end
        if (eres == 1) epa = ((64'(m_pa[idx]) & mask) | (lk_va & ~mask)) & 64'h1FF_FFFF_E000;
      end
    end
    chk(req, "res", 64'(lk_res), 64'(eres));
    chk(req, "pa", 64'(lk_pa), epa);
    chk(req, "perm", {61'd0, lk_rd, lk_wr, lk_ex}, {61'd0, er, ew, ex});
    chk(req, "tag_access", tag_access, m_tag);
    chk(req, "fault_status", 64'(fault_status), 64'(m_fsr));
    chk(req, "fault_addr", fault_addr, m_far);
    chk(req, "used", entry_used, m_used);
    @(posedge clk);
    if (eres >= 2) m_tag = {lk_va[63:13], ctx};
    if (eres == 3 || eres == 4 || eres == 6) begin
      m_fsr = {cause, priv_mode, !lk_instr && lk_nofault, !lk_instr && lk_write, cls, m_fsr[0], 1'b1};
      m_far = lk_va;
    end
    if (eres == 1) m_used[idx] = 1'b1;
    if (fill_en) begin
      m_va[fill_idx] = {fill_vpn, 13'd0}; m_cx[fill_idx] = fill_ctx;
      m_pa[fill_idx] = {fill_ppn, 13'd0}; m_sz[fill_idx] = int'(fill_size);
      m_v[fill_idx] = fill_valid; m_g[fill_idx] = fill_global; m_p[fill_idx] = fill_priv;
      m_w[fill_idx] = fill_writable; m_n[fill_idx] = fill_nfo; m_s[fill_idx] = fill_side;
      m_used[fill_idx] = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic set_fill(input int idx, input logic [63:0] va, input logic [12:0] cx,
                          input logic [40:0] pa, input logic [1:0] sz, input logic [5:0] attr);
    fill_en = 1; fill_idx = 6'(idx); fill_vpn = va[63:13]; fill_ctx = cx; fill_ppn = pa[40:13];
    fill_size = sz;
    {fill_valid, fill_global, fill_priv, fill_writable, fill_nfo, fill_side} = attr;
  endtask

  task automatic fill(input int idx, input logic [63:0] va, input logic [12:0] cx,
                      input logic [40:0] pa, input logic [1:0] sz, input logic [5:0] attr, input string req);
    set_fill(idx, va, cx, pa, sz, attr);
    tick(req);
    fill_en = 0;
  endtask

  task automatic set_look(input logic [63:0] va, input bit ins, input logic [1:0] sp,
                          input bit usr, input bit wr, input bit nf);
    lk_valid = 1; lk_va = va; lk_instr = ins; lk_space = sp; lk_user = usr;
    lk_write = wr; lk_nofault = nf;
  endtask

  task automatic look(input logic [63:0] va, input bit ins, input logic [1:0] sp,
                      input bit usr, input bit wr, input bit nf, input string req);
    set_look(va, ins, sp, usr, wr, nf);
    tick(req);
    lk_valid = 0;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired");
    if (!done) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // attr = {valid, global, priv, writable, nfo, side}
  initial begin
    for (int i = 0; i < N; i++) begin
      m_va[i] = 0; m_cx[i] = 0; m_pa[i] = 0; m_sz[i] = 0;
      m_v[i] = 0; m_g[i] = 0; m_p[i] = 0; m_w[i] = 0; m_n[i] = 0; m_s[i] = 0;
    end
    m_used = 0; m_fsr = 0; m_far = 0; m_tag = 0;
    rst_n = 0; fill_en = 0; fill_idx = 0; fill_vpn = 0; fill_ctx = 0; fill_ppn = 0; fill_size = 0;
    {fill_valid, fill_global, fill_priv, fill_writable, fill_nfo, fill_side} = 0;
    lk_valid = 0; lk_va = 0; lk_instr = 0; lk_space = 0; lk_user = 0; lk_write = 0; lk_nofault = 0;
    trap_level_nz = 0; priv_mode = 0; primary_ctx = 7; secondary_ctx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tick("R12");
    // basic 8 KB page
    fill(5, 64'h0000_1234_5678_A000, 7, 41'h1_2345_6000, 0, 6'b100100, "R5");
    look(64'h0000_1234_5678_A123, 0, 0, 0, 0, 0, "R1");
    look(64'h0000_1234_5678_A000, 0, 0, 0, 1, 0, "R10");
    primary_ctx = 8;
    look(64'h0000_1234_5678_A000, 0, 0, 0, 0, 0, "R9");
    secondary_ctx = 7;
    look(64'h0000_1234_5678_A000, 0, 1, 0, 0, 0, "R3");
    look(64'h0000_1234_5678_A000, 0, 2, 0, 0, 0, "R3");
    look(64'h0000_1234_5678_C000, 0, 1, 0, 0, 0, "R1");
    // large pages
    fill(6, 64'h0000_00AB_C000_0000, 3, 41'h0_1FC0_0000, 3, 6'b110000, "R1");
    look(64'h0000_00AB_C03F_E000, 0, 0, 0, 0, 0, "R2");
    look(64'h0000_00AB_C040_0000, 0, 2, 0, 0, 0, "R1");
    fill(7, 64'h0000_0000_0081_0000, 8, 41'h1_0000_0000, 1, 6'b100000, "R5");
    look(64'h0000_0000_0081_E000, 0, 0, 0, 0, 0, "R2");
    look(64'h0000_0000_0082_0000, 0, 0, 0, 0, 0, "R1");
    fill(8, 64'h0000_0000_0100_0000, 8, 41'h0_F000_0000, 2, 6'b100100, "R5");
    look(64'h0000_0000_0107_E000, 0, 0, 0, 1, 0, "R2");
    look(64'h0000_0000_0108_0000, 0, 0, 0, 0, 0, "R1");
    // overlapping entries
    fill(20, 64'h0000_0000_5000_0000, 8, 41'h0_0AAA_A000, 0, 6'b100100, "R4");
    fill(30, 64'h0000_0000_5000_0000, 8, 41'h0_0BBB_B000, 0, 6'b100100, "R4");
    look(64'h0000_0000_5000_0000, 0, 0, 0, 0, 0, "R4");
    fill(20, 64'h0000_0000_5000_0000, 8, 41'h0_0AAA_A000, 0, 6'b000100, "R5");
    look(64'h0000_0000_5000_0000, 0, 0, 0, 0, 0, "R4");
    fill(3, 64'h0000_0000_5000_0000, 1, 41'h0_0CCC_C000, 0, 6'b110000, "R4");
    look(64'h0000_0000_5000_0000, 0, 0, 0, 0, 0, "R4");
    // instruction side
    primary_ctx = 5;
    fill(40, 64'h0000_0000_7000_0000, 5, 41'h0_0700_0000, 0, 6'b101000, "R5");
    look(64'h0000_0000_7000_0000, 1, 0, 0, 0, 0, "R11");
    trap_level_nz = 1;
    look(64'h0000_0000_7000_0000, 1, 0, 0, 0, 0, "R3");
    trap_level_nz = 0; priv_mode = 0;
    look(64'h0000_0000_7000_0000, 1, 0, 1, 0, 0, "R11");
    // data faults
    fill(41, 64'h0000_0000_7100_0000, 5, 41'h0_0710_0000, 0, 6'b101011, "R5");
    look(64'h0000_0000_7100_0040, 0, 0, 1, 0, 0, "R6");
    priv_mode = 1;
    look(64'h0000_0000_7100_0080, 0, 0, 0, 0, 1, "R6");
    fill(42, 64'h0000_0000_7200_0000, 5, 41'h0_0720_0000, 0, 6'b100000, "R5");
    look(64'h0000_0000_7200_0000, 0, 0, 0, 1, 0, "R7");
    look(64'h0000_0000_7100_0000, 0, 0, 1, 1, 0, "R7");
    look(64'h0000_0000_7200_0000, 0, 0, 0, 0, 0, "R11");
    look(64'h0000_0000_7300_0000, 0, 0, 0, 0, 0, "R8");
    // fill and hit on the same entry in one cycle
    set_fill(42, 64'h0000_0000_7400_0000, 5, 41'h0_0740_0000, 0, 6'b100100);
    set_look(64'h0000_0000_7200_0000, 0, 0, 0, 0, 0);
    tick("R5");
    fill_en = 0; lk_valid = 0;
    look(64'h0000_0000_7200_0000, 0, 0, 0, 0, 0, "R5");
    look(64'h0000_0000_7400_0000, 0, 0, 0, 1, 0, "R10");
    tick("R12");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule